// File: doc/BRIEF.md
# ADC Output Demultiplexer with Decimation

This block sits behind an 8-bit converter core. Each cycle of the sample clock it accepts one sample in offset binary, together with an overrange flag. It distributes the samples over two 8-bit output ports, a primary port and an auxiliary port. It also drives a data-ready clock, which downstream logic uses to capture the ports, and a reset output that lets downstream devices align to the first update.

Two static pins choose the operating mode. With the demultiplexer enable pin low, every sample goes straight to the primary port. With it high, the select pin picks one of two modes. Low gives a 1:2 split, where a pair of consecutive samples leaves together on the auxiliary and primary ports. High gives decimation, where only every fourth sample is kept and the kept samples are paired across the two ports. The mode is captured once, on the first clock edge after reset is released. Changing the pins later has no effect until the next reset.

Top module: `adc_demux_top`

## Requirements
- R1: While `rst_n` is low, `pri_data` and `aux_data` are 0, `ovr_out` is 0, `drdy` is 0 and `rst_out` is 1.
- R2: Mode pins are decoded as follows: `demux_en`=0 selects pass-through, `demux_en`=1 with `div_sel`=0 selects 1:2 split, and `demux_en`=1 with `div_sel`=1 selects decimate-by-4. The decoded mode is captured on the first rising edge after `rst_n` goes high. Pin changes after that edge do not alter behaviour until the next reset.
- R3: In pass-through, the sample consumed at an edge appears on `pri_data` right after that edge, and `aux_data` keeps its value (0 after reset).
- R4: In 1:2 split, samples are numbered k=0,1,2… from the first consumed sample. An even-k sample is staged. At the edge that consumes the following odd-k sample, `aux_data` takes the staged sample and `pri_data` takes the odd-k sample, both together. Between such edges both ports hold.
- R5: In decimate-by-4, sample k with k mod 8 = 0 is staged. At the edge that consumes sample k mod 8 = 4, `aux_data` takes the staged sample and `pri_data` takes that sample. All other samples are discarded, and the ports hold between updates.
- R6: `ovr_out` changes only with a port update. It equals the OR of the overrange flags of the samples placed on the ports in that update: one sample in pass-through, two in the other modes.
- R7: `drdy` changes only at edges that consume a sample. In pass-through it toggles at every sample, so its first edge is rising and both edges mark updates. In 1:2 split it equals k mod 2 after consuming sample k. In decimate-by-4 it is 1 after consuming samples with k mod 8 in 4..7 and 0 otherwise. In the two demultiplexed modes every port update therefore coincides with a rising edge of `drdy`.
- R8: After reset release, `rst_out` stays 1 until the edge of the first port update, falls at that edge, and stays 0 until the next reset.
- R9: No sample is consumed at the mode-capture edge. Sample k=0 is the one presented before the second rising edge after release, and one sample is consumed per clock after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| demux_en | input | 1 | Demultiplexer enable mode pin |
| div_sel | input | 1 | Split/decimate select mode pin |
| smp_data | input | 8 | Converter sample, offset binary, bit 0 = LSB |
| smp_ovr | input | 1 | Overrange flag of the sample |
| pri_data | output | 8 | Primary output port, bit 0 = LSB |
| aux_data | output | 8 | Auxiliary output port, bit 0 = LSB |
| ovr_out | output | 1 | Overrange of the current update |
| drdy | output | 1 | Data-ready clock |
| rst_out | output | 1 | Reset output for downstream alignment |

## Verification
Pass-through is swept with all 256 sample codes, which shows that no bit is lost or swapped on the primary port and that the auxiliary port never moves. The split and decimation modes use a sequence with a large odd step and an overrange pattern of period five. That pattern makes the pair partners differ and sets the flag on only one partner, so swapped ports, wrong pairing phase, wrong kept samples and an overrange taken from a single sample are each detected. Every mode is run with its pins toggled mid-stream, so a design that follows the live pins instead of the captured mode is caught.

// File: rtl/adc_demux_pkg.sv
`timescale 1ns/1ps
package adc_demux_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_DEC4  = 2'd2
  } mode_e;

  localparam int DEC_FACTOR = 4;
  localparam int DEC_SPAN   = 2 * DEC_FACTOR;
  localparam int PHASE_W    = $clog2(DEC_SPAN);
endpackage

// File: rtl/adc_mode_latch.sv
`timescale 1ns/1ps
module adc_mode_latch
  import adc_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  demux_en,
  input  logic  div_sel,
  output mode_e mode_q,
  output logic  armed_q
);
  mode_e mode_d;
  logic  cap_en;

  always_comb begin
    cap_en = !armed_q;
    if (!demux_en)    mode_d = MODE_PASS;
    else if (div_sel) mode_d = MODE_DEC4;
    else              mode_d = MODE_SPLIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PASS;
      armed_q <= 1'b0;
    end else if (cap_en) begin
      mode_q  <= mode_d;
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_phase_ctr.sv
`timescale 1ns/1ps
module adc_phase_ctr #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [PH_W-1:0] ph_q
);
  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph_q <= '0;
    else if (adv) ph_q <= ph_d;
  end
endmodule

// File: rtl/adc_port_stage.sv
`timescale 1ns/1ps
module adc_port_stage
  import adc_demux_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              adv,
  input  logic [PH_W-1:0]   ph,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_ovr,
  output logic [DATA_W-1:0] pri_q,
  output logic [DATA_W-1:0] aux_q,
  output logic              ovr_q,
  output logic              upd
);
  localparam logic [PH_W-1:0] PH_KEEP0 = '0;
  localparam logic [PH_W-1:0] PH_KEEP1 = PH_W'(1 << (PH_W - 1));

  logic [DATA_W-1:0] stg_data;
  logic              stg_ovr;
  logic              stg_en;
  logic [DATA_W-1:0] pri_d;
  logic [DATA_W-1:0] aux_d;
  logic              ovr_d;

  always_comb begin
    stg_en = 1'b0;
    upd    = 1'b0;
    pri_d  = s_data;
    aux_d  = stg_data;
    ovr_d  = stg_ovr | s_ovr;
    case (mode)
      MODE_SPLIT: begin
        stg_en = adv && !ph[0];
        upd    = adv && ph[0];
      end
      MODE_DEC4: begin
        stg_en = adv && (ph == PH_KEEP0);
        upd    = adv && (ph == PH_KEEP1);
      end
      default: begin
        upd   = adv;
        aux_d = aux_q;
        ovr_d = s_ovr;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_data <= '0;
      stg_ovr  <= 1'b0;
    end else if (stg_en) begin
      stg_data <= s_data;
      stg_ovr  <= s_ovr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      aux_q <= '0;
      ovr_q <= 1'b0;
    end else if (upd) begin
      pri_q <= pri_d;
      aux_q <= aux_d;
      ovr_q <= ovr_d;
    end
  end
endmodule

// File: rtl/adc_drdy_gen.sv
`timescale 1ns/1ps
module adc_drdy_gen
  import adc_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  adv,
  input  logic  ph_lsb,
  input  logic  ph_msb,
  input  logic  upd,
  output logic  drdy_q,
  output logic  rst_out_q
);
  logic drdy_d;

  always_comb begin
    case (mode)
      MODE_SPLIT: drdy_d = ph_lsb;
      MODE_DEC4:  drdy_d = ph_msb;
      default:    drdy_d = !drdy_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   drdy_q <= 1'b0;
    else if (adv) drdy_q <= drdy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rst_out_q <= 1'b1;
    else if (upd) rst_out_q <= 1'b0;
  end
endmodule

// File: rtl/adc_demux_top.sv
`timescale 1ns/1ps
module adc_demux_top
  import adc_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              demux_en,
  input  logic              div_sel,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_ovr,
  output logic [DATA_W-1:0] pri_data,
  output logic [DATA_W-1:0] aux_data,
  output logic              ovr_out,
  output logic              drdy,
  output logic              rst_out
);
  localparam int PH_W = PHASE_W;

  mode_e           mode_q;
  logic            armed_q;
  logic [PH_W-1:0] ph_q;
  logic            upd;

  adc_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .demux_en (demux_en),
    .div_sel  (div_sel),
    .mode_q   (mode_q),
    .armed_q  (armed_q)
  );

  adc_phase_ctr #(.PH_W(PH_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (armed_q),
    .ph_q  (ph_q)
  );

  adc_port_stage #(.DATA_W(DATA_W), .PH_W(PH_W)) u_ports (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_q),
    .adv    (armed_q),
    .ph     (ph_q),
    .s_data (smp_data),
    .s_ovr  (smp_ovr),
    .pri_q  (pri_data),
    .aux_q  (aux_data),
    .ovr_q  (ovr_out),
    .upd    (upd)
  );

  adc_drdy_gen u_drdy (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .adv       (armed_q),
    .ph_lsb    (ph_q[0]),
    .ph_msb    (ph_q[PH_W-1]),
    .upd       (upd),
    .drdy_q    (drdy),
    .rst_out_q (rst_out)
  );
endmodule

// File: rtl/adc_demux_chk.sv
`timescale 1ns/1ps
module adc_demux_chk
  import adc_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input mode_e             mode_q,
  input logic              armed_q,
  input logic [DATA_W-1:0] pri_data,
  input logic [DATA_W-1:0] aux_data,
  input logic              ovr_out,
  input logic              drdy,
  input logic              rst_out
);
  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(mode_q));

  assert_aux_hold_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PASS) |=> $stable(aux_data));

  assert_ports_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_PASS && !$rose(drdy)) |-> ($stable(pri_data) && $stable(aux_data)));

  assert_ovr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_PASS && !$rose(drdy)) |-> $stable(ovr_out));

  assert_split_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SPLIT && armed_q && $past(armed_q)) |=> (drdy != $past(drdy)));

  assert_rst_out_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out |=> !rst_out);

  assert_rst_out_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> $rose(drdy));
endmodule

bind adc_demux_top adc_demux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_q   (mode_q),
  .armed_q  (armed_q),
  .pri_data (pri_data),
  .aux_data (aux_data),
  .ovr_out  (ovr_out),
  .drdy     (drdy),
  .rst_out  (rst_out)
);

// File: tb/sim_adc_demux_top.sv
`timescale 1ns/1ps
module sim_adc_demux_top;
  logic       clk;
  logic       rst_n;
  logic       demux_en;
  logic       div_sel;
  logic [7:0] smp_data;
  logic       smp_ovr;
  logic [7:0] pri_data;
  logic [7:0] aux_data;
  logic       ovr_out;
  logic       drdy;
  logic       rst_out;

  int  checks;
  int  failures;
  bit  done;

  logic [7:0] ep, ea, hs;
  logic       eo, ed, er, ho;

  adc_demux_top u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .demux_en (demux_en),
    .div_sel  (div_sel),
    .smp_data (smp_data),
    .smp_ovr  (smp_ovr),
    .pri_data (pri_data),
    .aux_data (aux_data),
    .ovr_out  (ovr_out),
    .drdy     (drdy),
    .rst_out  (rst_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic en, input logic sel);
    @(negedge clk);
    rst_n    = 1'b0;
    demux_en = en;
    div_sel  = sel;
    smp_data = 8'hFF;
    smp_ovr  = 1'b1;
    @(negedge clk);
    chk(pri_data == 8'h00, "R1 pri", pri_data, 0);
    chk(aux_data == 8'h00, "R1 aux", aux_data, 0);
    chk({ovr_out, drdy, rst_out} == 3'b001, "R1 ovr/drdy/rst_out",
        {ovr_out, drdy, rst_out}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: capture edge consumes nothing although a sample is presented
    chk(pri_data == 8'h00 && ovr_out == 1'b0, "R9 no consume at capture",
        {ovr_out, pri_data}, 0);
    chk({drdy, rst_out} == 2'b01, "R9 drdy/rst_out idle", {drdy, rst_out}, 1);
    ep = 8'h00; ea = 8'h00; eo = 1'b0; ed = 1'b0; er = 1'b1;
    hs = 8'h00; ho = 1'b0;
  endtask

  // m: 0 pass, 1 split, 2 decimate; pins are disturbed at sample flip_k (R2)
  task automatic run(input int m, input int n, input int mul, input int add,
                     input int flip_k, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] s;
      logic       o;
      s = 8'((k * mul + add) & 255);
      o = ((k % 5) == 3);
      smp_data = s;
      smp_ovr  = o;
      if (k == flip_k) begin
        demux_en = ~demux_en;
        div_sel  = ~div_sel;
      end
      @(posedge clk);
      @(negedge clk);
      case (m)
        0: begin
          ep = s; eo = o; ed = ~ed; er = 1'b0;
        end
        1: begin
          if ((k % 2) == 1) begin
            ea = hs; ep = s; eo = ho | o; er = 1'b0;
          end else begin
            hs = s; ho = o;
          end
          ed = 1'(k % 2);
        end
        default: begin
          if ((k % 8) == 0) begin
            hs = s; ho = o;
          end else if ((k % 8) == 4) begin
            ea = hs; ep = s; eo = ho | o; er = 1'b0;
          end
          ed = ((k % 8) >= 4);
        end
      endcase
      chk(pri_data == ep, {tag, " pri"}, pri_data, ep);
      chk(aux_data == ea, {tag, " aux"}, aux_data, ea);
      chk(ovr_out == eo, "R6 ovr_out", ovr_out, eo);
      chk(drdy == ed, "R7 drdy", drdy, ed);
      chk(rst_out == er, "R8 rst_out", rst_out, er);
      if (k > flip_k)
        chk(pri_data == ep && aux_data == ea, "R2 mode held after pin change",
            {pri_data, aux_data}, {ep, ea});
    end
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; demux_en = 1'b0; div_sel = 1'b0;
    smp_data = 8'h00; smp_ovr = 1'b0;
    // R3 pass-through, every code once
    do_reset(1'b0, 1'b0);
    run(0, 256, 1, 90, 100, "R3");
    // R4 1:2 split, pins disturbed mid-run
    do_reset(1'b1, 1'b0);
    run(1, 64, 37, 11, 20, "R4");
    // R5 decimate-by-4, pins disturbed mid-run
    do_reset(1'b1, 1'b1);
    run(2, 80, 37, 200, 30, "R5");
    // split again with a different sequence to vary pairing data
    do_reset(1'b1, 1'b0);
    run(1, 40, 151, 3, 7, "R4");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule